// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block connects a synchronous host to an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. The host presents one request at a time over a valid/ready handshake: a read/write flag, a word address, write data and a per-lane byte mask. A read returns its data with a one-cycle response strobe. On the memory side the block drives active-low chip select, write strobe, output enable and one active-low byte enable per lane. It also drives the address and a split data bus (outgoing data, incoming data, drive enable) that a pad ring joins into one bidirectional bus.

Every analog timing figure of the memory is a nanosecond parameter. The block turns each into a whole number of clock cycles with a ceiling against the clock-period parameter, never less than one. From these counts it sequences the strobes, holds the address and data across the edge that ends a write, and leaves the data bus undriven after a read until the memory has let go of it. Writes are made with output enable held high, so the bus never has two drivers. Back-pressure: `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the request inputs are ignored and the host must hold or withdraw them. There is no back-pressure on the response.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both byte enables are high (inactive), the data bus drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the access and its recovery are complete. A request presented while `req_ready` is low has no effect on the memory.
- R3: A write holds chip select, write strobe and the enabled byte enables low together for exactly N_WR cycles, where N_WR is the largest cycle count of the write-pulse, data-setup, address-setup and cycle-time parameters. Output enable stays high for the whole write.
- R4: Write address and data appear in the cycle the write strobe falls and stay unchanged and driven through the first cycle after the strobes rise.
- R5: Mask bit 0 selects the lane on data bits 7..0 (byte enable bit 0) and mask bit 1 selects bits 15..8 (byte enable bit 1). A lane whose mask bit is 0 keeps its byte enable high, and its memory byte is left unchanged by a write.
- R6: A read holds chip select and output enable low with the write strobe high for exactly N_RD cycles, the largest cycle count of the address-access, output-enable-access, byte-enable-access and cycle-time parameters. Data is captured on the edge that ends this window, so `rsp_valid` rises N_RD cycles after the accepting edge.
- R7: `rsp_valid` is a one-cycle pulse carrying the read data. Lanes whose mask bit was 0 read back as zero.
- R8: After a read, the data bus drive enable stays low for at least N_TURN cycles, the cycle count of the bus-release parameter, after output enable rises.
- R9: The data bus drive enable is never high while output enable is low.
- R10: Each cycle count is the ceiling of the nanosecond value over the clock period, and is never less than one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (18) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_mask | input | DATA_W/8 (2) | Lane select, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | DATA_W (16) | Read data |
| mem_addr | output | ADDR_W (18) | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DATA_W/8 (2) | Byte enables, active low, bit 0 = bits 7..0 |
| mem_dq_out | output | DATA_W (16) | Data toward the memory |
| mem_dq_in | input | DATA_W (16) | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The bench builds the block with a 4 ns clock and raises the address-access parameter to 10 ns, leaving the others at their defaults. That makes the read window 3 cycles, set by a ceiling over a value that is not a whole number of periods, while the write pulse is 2 cycles and the bus release 1 cycle. The read and write windows therefore differ, and a wrong rounding or a wrong choice of the governing parameter shows as a wrong strobe width or a wrong read latency. With a one-cycle release, a write issued right behind a read tests the turnaround gap at its tightest.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WR_HOLD,
    ST_RD,
    ST_RD_REL
  } asram_state_e;

  // R10: ceiling division of a picosecond figure by the clock period, floor of one
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10

endmodule

// File: rtl/asram_lane.sv
`timescale 1ns/1ps
module asram_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [LANE_W-1:0] wbyte,
  input  logic              capture,
  input  logic              lane_en,
  input  logic [LANE_W-1:0] dq_in_byte,
  output logic [LANE_W-1:0] dq_out_byte,
  output logic [LANE_W-1:0] rbyte
);

  logic [LANE_W-1:0] wr_q;
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (accept) begin
      wr_q <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (capture) begin
      rd_q <= lane_en ? dq_in_byte : '0;
    end
  end

  assign dq_out_byte = wr_q;
  assign rbyte       = rd_q;

  AST_LANE_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !lane_en) |=> (rbyte == '0)); // R7

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned N_RD   = 2,
  parameter int unsigned N_WR   = 2,
  parameter int unsigned N_TURN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic [LANES-1:0] mask_q,
  output logic             rsp_valid,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  input  logic             tmr_expired,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [LANES-1:0] mem_be_n,
  output logic             mem_dq_oe
);

  asram_state_e st_q, st_nxt;
  logic [LANES-1:0] mask_nxt;
  logic             sel_nxt;

  always_comb begin
    st_nxt   = st_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            st_nxt  = ST_WR;
            tmr_val = CNT_W'(N_WR - 1);
          end else begin
            st_nxt  = ST_RD;
            tmr_val = CNT_W'(N_RD - 1);
          end
        end
      end
      ST_WR:      if (tmr_expired) st_nxt = ST_WR_HOLD;
      ST_WR_HOLD: st_nxt = ST_IDLE;
      ST_RD: begin
        if (tmr_expired) begin
          capture  = 1'b1;
          st_nxt   = ST_RD_REL;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_TURN - 1);
        end
      end
      ST_RD_REL:  if (tmr_expired) st_nxt = ST_IDLE;
      default:    st_nxt = ST_IDLE;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign mask_nxt  = accept ? req_mask : mask_q;
  assign sel_nxt   = (st_nxt == ST_WR) || (st_nxt == ST_RD);

  // strobes are registered from the next state so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mask_q    <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      mask_q    <= mask_nxt;
      mem_ce_n  <= !sel_nxt;
      mem_we_n  <= (st_nxt != ST_WR);
      mem_oe_n  <= (st_nxt != ST_RD);
      mem_dq_oe <= (st_nxt == ST_WR) || (st_nxt == ST_WR_HOLD);
      rsp_valid <= capture;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_be_n[l] <= 1'b1;
      end else begin
        mem_be_n[l] <= !(sel_nxt && mask_nxt[l]);
      end
    end
  end

  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R3
  AST_RD_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n); // R6
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7
  AST_WR_END_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R4
  AST_BE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be_n != {LANES{1'b1}}) |-> !mem_ce_n); // R5
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_dq_oe); // R8

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 18,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned CLK_PS       = 4000,
  parameter int unsigned T_ACC_PS     = 8000,
  parameter int unsigned T_OE_ACC_PS  = 5000,
  parameter int unsigned T_BE_ACC_PS  = 5000,
  parameter int unsigned T_WPULSE_PS  = 6000,
  parameter int unsigned T_DSETUP_PS  = 4000,
  parameter int unsigned T_ASETUP_PS  = 6000,
  parameter int unsigned T_RELEASE_PS = 4000,
  parameter int unsigned T_CYCLE_PS   = 8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned N_CYC  = ps_to_cycles(T_CYCLE_PS, CLK_PS);
  localparam int unsigned N_RD   = max4(ps_to_cycles(T_ACC_PS, CLK_PS),
                                        ps_to_cycles(T_OE_ACC_PS, CLK_PS),
                                        ps_to_cycles(T_BE_ACC_PS, CLK_PS), N_CYC);
  localparam int unsigned N_WR   = max4(ps_to_cycles(T_WPULSE_PS, CLK_PS),
                                        ps_to_cycles(T_DSETUP_PS, CLK_PS),
                                        ps_to_cycles(T_ASETUP_PS, CLK_PS), N_CYC);
  localparam int unsigned N_TURN = ps_to_cycles(T_RELEASE_PS, CLK_PS);
  localparam int unsigned N_MAX  = max4(N_RD, N_WR, N_TURN, 1);
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

  logic             accept;
  logic             capture;
  logic [LANES-1:0] mask_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic [ADDR_W-1:0] addr_q;

  asram_seq #(
    .LANES (LANES),
    .CNT_W (CNT_W),
    .N_RD  (N_RD),
    .N_WR  (N_WR),
    .N_TURN(N_TURN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_mask   (req_mask),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture),
    .mask_q     (mask_q),
    .rsp_valid  (rsp_valid),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_expired(tmr_expired),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_oe  (mem_dq_oe)
  );

  asram_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end
  assign mem_addr = addr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    asram_lane #(.LANE_W(8)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .wbyte      (req_wdata[l*8 +: 8]),
      .capture    (capture),
      .lane_en    (mask_q[l]),
      .dq_in_byte (mem_dq_in[l*8 +: 8]),
      .dq_out_byte(mem_dq_out[l*8 +: 8]),
      .rbyte      (rsp_rdata[l*8 +: 8])
    );
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R4
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R4
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int N_RD_EXP   = 3; // ceil(10 ns / 4 ns)
  localparam int N_WR_EXP   = 2; // ceil(6 ns / 4 ns)
  localparam int N_TURN_EXP = 1; // ceil(4 ns / 4 ns)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  int checks = 0;
  int errors = 0;

  always #2ns clk = ~clk;

  asram_ctrl #(.CLK_PS(4000), .T_ACC_PS(10000)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // memory model and independent shadow of expected contents
  logic [15:0] ram [256];
  logic [15:0] shadow [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 16'(i * 16'h0101) ^ 16'hA5A5;
      shadow[i] = 16'(i * 16'h0101) ^ 16'hA5A5;
    end
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      mem_dq_in[l*8 +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
                            ? ram[mem_addr[7:0]][l*8 +: 8] : 8'h00;
    end
  end

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      for (int l = 0; l < 2; l++) begin
        if (!mem_be_n[l]) ram[mem_addr[7:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
      end
    end
  end

  // strobe monitor
  int we_run = 0, last_we = 0, oe_run = 0, last_oe = 0;
  int since_oe = 0, min_gap = 99, clash = 0;
  logic prev_dq = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin last_we = we_run; we_run = 0; end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
      if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) clash++;
      if (!mem_oe_n) since_oe = 0;
      else begin
        if (mem_dq_oe && !prev_dq && since_oe < min_gap) min_gap = since_oe;
        since_oe++;
      end
      prev_dq = mem_dq_oe;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] m);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 0);
    for (int l = 0; l < 2; l++) if (m[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    wait_ready();
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] m,
                         output logic [15:0] d, output int lat);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
    @(posedge clk);
    lat = 0;
    do begin
      if (lat == 0) begin @(negedge clk); req_valid = 1'b0; end
      else @(negedge clk);
      if (!rsp_valid) begin @(posedge clk); lat++; end
      else break;
    end while (lat < 20);
    d = rsp_rdata;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 response lasts one cycle", 32'(rsp_valid), 0);
    wait_ready();
  endtask

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic t_reset();
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high",
        {29'b0, mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(mem_be_n == 2'b11, "R1 byte enables high", 32'(mem_be_n), 3);
    chk(!mem_dq_oe, "R1 bus not driven", 32'(mem_dq_oe), 0);
    chk(req_ready && !rsp_valid, "R1 ready high, no response",
        {30'b0, req_ready, rsp_valid}, 2);
  endtask

  task automatic t_full_write_read();
    logic [15:0] d; int lat;
    do_write(18'h00010, 16'h1234, 2'b11);
    chk(last_we == N_WR_EXP, "R3 write strobe width (R10)", 32'(last_we), N_WR_EXP);
    do_read(18'h00010, 2'b11, d, lat);
    chk(d == 16'h1234, "R6 full-word read data", 32'(d), 32'h1234);
    chk(lat == N_RD_EXP, "R6 read latency (R10)", 32'(lat), N_RD_EXP);
    chk(last_oe == N_RD_EXP, "R6 output enable width", 32'(last_oe), N_RD_EXP);
  endtask

  task automatic t_byte_lanes();
    logic [15:0] d; int lat;
    do_write(18'h00020, 16'hAAAA, 2'b11);
    do_write(18'h00020, 16'h5B6C, 2'b10);
    do_read(18'h00020, 2'b11, d, lat);
    chk(d == shadow[8'h20], "R5 upper lane only written", 32'(d), 32'(shadow[8'h20]));
    do_write(18'h00021, 16'h0F0E, 2'b01);
    do_read(18'h00021, 2'b11, d, lat);
    chk(d == shadow[8'h21], "R5 lower lane only written", 32'(d), 32'(shadow[8'h21]));
    do_write(18'h00022, 16'hFFFF, 2'b00);
    do_read(18'h00022, 2'b11, d, lat);
    chk(d == shadow[8'h22], "R5 empty mask leaves word", 32'(d), 32'(shadow[8'h22]));
  endtask

  task automatic t_masked_read();
    logic [15:0] d; int lat;
    do_read(18'h00030, 2'b01, d, lat);
    chk(d == masked(shadow[8'h30], 2'b01), "R7 upper lane reads zero",
        32'(d), 32'(masked(shadow[8'h30], 2'b01)));
    do_read(18'h00031, 2'b10, d, lat);
    chk(d == masked(shadow[8'h31], 2'b10), "R7 lower lane reads zero",
        32'(d), 32'(masked(shadow[8'h31], 2'b10)));
  endtask

  task automatic t_ignored_request();
    logic [15:0] d; int lat;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00040; req_mask = 2'b11;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00041; req_wdata = 16'hDEAD;
    req_mask = 2'b11;
    chk(!req_ready, "R2 busy during read", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_ready();
    do_read(18'h00041, 2'b11, d, lat);
    chk(d == shadow[8'h41], "R2 request while busy ignored", 32'(d), 32'(shadow[8'h41]));
  endtask

  task automatic t_turnaround();
    logic [15:0] d; int lat;
    min_gap = 99;
    do_read(18'h00050, 2'b11, d, lat);
    do_write(18'h00051, 16'h7E57, 2'b11);
    chk(min_gap >= N_TURN_EXP && min_gap != 99, "R8 release gap before drive",
        32'(min_gap), N_TURN_EXP);
    chk(clash == 0, "R9 no drive with output enable low", 32'(clash), 0);
    do_read(18'h00051, 2'b11, d, lat);
    chk(d == 16'h7E57, "R4 data held through write end", 32'(d), 32'h7E57);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write_read();
    t_byte_lanes();
    t_masked_read();
    t_ignored_request();
    t_turnaround();
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 4ns);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule